// File: doc/BRIEF.md
# Speculative Register State with In-Order Result Buffer

This block keeps the register state for an out-of-order core that renames by value. A speculative register table, indexed by architectural register number, holds for every register either its newest value (marked available) or the identity of the in-flight operation that will produce it. A circular result buffer hands out serial identifiers to renamed operations in program order. It collects their results as they finish, and it retires them oldest first into a committed register table.

Each cycle the rename side presents source register numbers and, optionally, a destination. It gets back a value or a producer identifier for each source, and the identifier given to the new operation. Finished results come back by identifier and may carry a recovery flag. When a flagged operation reaches the oldest slot, the block discards everything in flight and reloads the speculative table from the committed one. The committed table feeds only that reload and never supplies operands.

Top module: `spec_rename_core`

## Requirements
- R1: After reset no rename is stalled, the next identifier is 0, every register reads as available with value 0, and nothing retires.
- R2: A source read returns available=1 and the speculative value when the register has no pending producer; otherwise it returns available=0 and the identifier of the newest operation writing that register.
- R3: Accepted operations receive identifiers 0,1,2,... modulo the buffer depth, with no free list. A destination marks its register pending on the new identifier from the next cycle on. A source naming the same register in the same operation still sees the earlier mapping.
- R4: While the buffer holds as many operations as its depth, the stall output is high and a presented rename changes nothing: the identifier does not advance and no mapping changes.
- R5: A result is stored in its buffer slot. The oldest operation retires only once its result is stored, at most one per cycle and in program order. Retirement shows the operation's identifier, destination and stored result.
- R6: A result updates the speculative table and makes its register available only when its identifier is still the newest producer of that register. A result from an older writer leaves the register pending on the newer one.
- R7: A result arriving in the same cycle as a source read of the register it is the newest producer for is forwarded to that read as available with the result value.
- R8: A retiring operation without the recovery flag writes its result into the committed table entry of its destination.
- R9: When the oldest completed operation carries the recovery flag, the recovery output and the stall output are high for that cycle and its result is not committed. From the next cycle on, every register reads as available with its committed value, the buffer is empty and the next identifier is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_src_idx | input | NSRC*AW | Source register numbers, source s in bits [s*AW +: AW] |
| ren_has_dst | input | 1 | Operation writes a destination register |
| ren_dst_idx | input | AW | Destination register number |
| ren_stall | output | 1 | Rename not accepted this cycle |
| ren_tag | output | TW | Identifier given to an accepted operation |
| src_ready | output | NSRC | Source s is available |
| src_value | output | NSRC*DW | Source value, valid when available |
| src_tag | output | NSRC*TW | Producer identifier, valid when not available |
| cmp_valid | input | 1 | A result is returned |
| cmp_tag | input | TW | Identifier of the finished operation |
| cmp_value | input | DW | Result value |
| cmp_flag | input | 1 | Operation requests recovery when it retires |
| grad_valid | output | 1 | Oldest operation retires this cycle |
| grad_tag | output | TW | Identifier of the retiring operation |
| grad_wr | output | 1 | Retiring operation has a destination |
| grad_dst | output | AW | Destination of the retiring operation |
| grad_value | output | DW | Result of the retiring operation |
| recover | output | 1 | Recovery happens this cycle |

## Verification
The bench builds the block with 8 registers, a depth of 8, two sources and 16-bit data. With so few registers, random destinations often hit the same register twice, which brings out older-writer results, same-cycle forwarding and reads that see the earlier mapping. A depth of 8 lets bursts of renames fill the buffer, so the full stall and identifier wraparound come up often. Rare recovery flags then check the reload against committed values that differ from the speculative ones.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;
   typedef enum logic [1:0] {
      GR_IDLE    = 2'd0,
      GR_COMMIT  = 2'd1,
      GR_RECOVER = 2'd2
   } grad_act_e;
endpackage

// File: rtl/sr_commit_file.sv
`timescale 1ns/1ps
module sr_commit_file #(
   parameter int NREG = 16,
   parameter int DW   = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_idx,
   input  logic [DW-1:0]      wr_data,
   output logic [NREG*DW-1:0] snap
);
   logic [DW-1:0] arch_q [NREG];

   initial assert (NREG >= 2) else $fatal(1, "NREG must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) arch_q[r] <= '0;
      end else if (wr_en) begin
         arch_q[wr_idx] <= wr_data;
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_snap
      assign snap[r*DW +: DW] = arch_q[r];
   end
endmodule

// File: rtl/sr_future_file.sv
`timescale 1ns/1ps
module sr_future_file #(
   parameter int NREG   = 16,
   parameter int DW     = 32,
   parameter int TW     = 4,
   parameter int NSRC   = 2,
   parameter bit FWD_EN = 1'b1,
   localparam int AW    = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NSRC*AW-1:0] rd_idx,
   output logic [NSRC-1:0]    rd_rdy,
   output logic [NSRC*DW-1:0] rd_val,
   output logic [NSRC*TW-1:0] rd_tag,
   input  logic               alloc_en,
   input  logic [AW-1:0]      alloc_idx,
   input  logic [TW-1:0]      alloc_tag,
   input  logic               res_en,
   input  logic [AW-1:0]      res_idx,
   input  logic [TW-1:0]      res_tag,
   input  logic [DW-1:0]      res_val,
   input  logic               restore,
   input  logic [NREG*DW-1:0] restore_vals
);
   logic [NREG-1:0] rdy_q;
   logic [DW-1:0]   val_q [NREG];
   logic [TW-1:0]   tag_q [NREG];
   logic [NREG-1:0] hit;

   initial assert (NSRC >= 1 && TW >= 1) else $fatal(1, "bad source count or tag width");

   for (genvar r = 0; r < NREG; r++) begin : g_hit
      assign hit[r] = res_en && (res_idx == AW'(r)) && !rdy_q[r] && (tag_q[r] == res_tag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= '1;
         for (int r = 0; r < NREG; r++) begin
            val_q[r] <= '0;
            tag_q[r] <= '0;
         end
      end else if (restore) begin
         rdy_q <= '1;
         for (int r = 0; r < NREG; r++) val_q[r] <= restore_vals[r*DW +: DW];
      end else begin
         for (int r = 0; r < NREG; r++) begin
            if (alloc_en && alloc_idx == AW'(r)) begin
               rdy_q[r] <= 1'b0;
               tag_q[r] <= alloc_tag;
            end else if (hit[r]) begin
               rdy_q[r] <= 1'b1;
               val_q[r] <= res_val;
            end
         end
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_rd
      logic [AW-1:0] idx;
      assign idx = rd_idx[s*AW +: AW];
      assign rd_tag[s*TW +: TW] = tag_q[idx];
      if (FWD_EN) begin : g_fwd
         assign rd_rdy[s] = rdy_q[idx] | hit[idx];
         assign rd_val[s*DW +: DW] = hit[idx] ? res_val : val_q[idx];
      end else begin : g_nofwd
         assign rd_rdy[s] = rdy_q[idx];
         assign rd_val[s*DW +: DW] = val_q[idx];
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_chk
      a_r6_ready_from_latest: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(!rdy_q[r] && !restore) && rdy_q[r]) |->
            $past(res_en && res_idx == AW'(r) && res_tag == tag_q[r]));
   end

   a_r3_alloc_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !restore) |=>
         (!rdy_q[$past(alloc_idx)] && tag_q[$past(alloc_idx)] == $past(alloc_tag)));

   a_r9_restore_all_ready: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> (rdy_q == '1));
endmodule

// File: rtl/sr_reorder_ring.sv
`timescale 1ns/1ps
module sr_reorder_ring #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   parameter int AW    = 4,
   localparam int TW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_en,
   input  logic          alloc_has,
   input  logic [AW-1:0] alloc_dst,
   output logic [TW-1:0] tail_tag,
   output logic          full,
   input  logic          cmp_en,
   input  logic [TW-1:0] cmp_tag,
   input  logic [DW-1:0] cmp_val,
   input  logic          cmp_exc,
   output logic          cmp_ok,
   output logic          cmp_has,
   output logic [AW-1:0] cmp_dst,
   input  logic          pop_en,
   input  logic          flush,
   output logic [TW-1:0] head_tag,
   output logic          head_done,
   output logic          head_has,
   output logic [AW-1:0] head_dst,
   output logic [DW-1:0] head_val,
   output logic          head_exc
);
   logic [DEPTH-1:0] busy_q, done_q, exc_q, has_q;
   logic [AW-1:0]    dst_q [DEPTH];
   logic [DW-1:0]    val_q [DEPTH];
   logic [TW-1:0]    head_q, tail_q;
   logic [CW-1:0]    count_q;

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $fatal(1, "DEPTH must be a power of two, at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         busy_q  <= '0;
         done_q  <= '0;
         exc_q   <= '0;
         has_q   <= '0;
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (cmp_en && cmp_ok) begin
            done_q[cmp_tag] <= 1'b1;
            exc_q[cmp_tag]  <= cmp_exc;
            val_q[cmp_tag]  <= cmp_val;
         end
         if (alloc_en) begin
            busy_q[tail_q] <= 1'b1;
            done_q[tail_q] <= 1'b0;
            exc_q[tail_q]  <= 1'b0;
            has_q[tail_q]  <= alloc_has;
            dst_q[tail_q]  <= alloc_dst;
            tail_q         <= tail_q + TW'(1);
         end
         if (pop_en) begin
            busy_q[head_q] <= 1'b0;
            head_q         <= head_q + TW'(1);
         end
         count_q <= count_q + CW'(alloc_en) - CW'(pop_en);
      end
   end

   assign tail_tag  = tail_q;
   assign full      = (count_q == CW'(DEPTH));
   assign cmp_ok    = busy_q[cmp_tag] & ~done_q[cmp_tag];
   assign cmp_has   = has_q[cmp_tag];
   assign cmp_dst   = dst_q[cmp_tag];
   assign head_tag  = head_q;
   assign head_done = busy_q[head_q] & done_q[head_q];
   assign head_has  = has_q[head_q];
   assign head_dst  = dst_q[head_q];
   assign head_val  = val_q[head_q];
   assign head_exc  = exc_q[head_q];

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (count_q < CW'(DEPTH)));

   a_r5_pop_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      pop_en |-> (head_done && count_q != '0));

   a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0 && tail_q == '0 && !head_done));
endmodule

// File: rtl/spec_rename_core.sv
`timescale 1ns/1ps
module spec_rename_core #(
   parameter int NREG   = 16,
   parameter int DW     = 32,
   parameter int DEPTH  = 16,
   parameter int NSRC   = 2,
   parameter bit FWD_EN = 1'b1,
   localparam int AW    = $clog2(NREG),
   localparam int TW    = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ren_valid,
   input  logic [NSRC*AW-1:0] ren_src_idx,
   input  logic               ren_has_dst,
   input  logic [AW-1:0]      ren_dst_idx,
   output logic               ren_stall,
   output logic [TW-1:0]      ren_tag,
   output logic [NSRC-1:0]    src_ready,
   output logic [NSRC*DW-1:0] src_value,
   output logic [NSRC*TW-1:0] src_tag,
   input  logic               cmp_valid,
   input  logic [TW-1:0]      cmp_tag,
   input  logic [DW-1:0]      cmp_value,
   input  logic               cmp_flag,
   output logic               grad_valid,
   output logic [TW-1:0]      grad_tag,
   output logic               grad_wr,
   output logic [AW-1:0]      grad_dst,
   output logic [DW-1:0]      grad_value,
   output logic               recover
);
   import sr_pkg::*;

   logic               full, head_done, head_has, head_exc;
   logic               cmp_ok, cmp_has;
   logic [AW-1:0]      cmp_dst, head_dst;
   logic [DW-1:0]      head_val;
   logic [TW-1:0]      head_tag, tail_tag;
   logic [NREG*DW-1:0] arch_snap;
   logic               alloc_en, res_en, pop_en;
   grad_act_e          act;

   always_comb begin
      act = GR_IDLE;
      if (head_done) act = head_exc ? GR_RECOVER : GR_COMMIT;
   end

   assign recover    = (act == GR_RECOVER);
   assign pop_en     = (act == GR_COMMIT);
   assign ren_stall  = full | recover;
   assign alloc_en   = ren_valid & ~ren_stall;
   assign res_en     = cmp_valid & cmp_ok & cmp_has & ~recover;
   assign ren_tag    = tail_tag;
   assign grad_valid = head_done;
   assign grad_tag   = head_tag;
   assign grad_wr    = head_has;
   assign grad_dst   = head_dst;
   assign grad_value = head_val;

   sr_reorder_ring #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_en),
      .alloc_has (ren_has_dst),
      .alloc_dst (ren_dst_idx),
      .tail_tag  (tail_tag),
      .full      (full),
      .cmp_en    (cmp_valid & ~recover),
      .cmp_tag   (cmp_tag),
      .cmp_val   (cmp_value),
      .cmp_exc   (cmp_flag),
      .cmp_ok    (cmp_ok),
      .cmp_has   (cmp_has),
      .cmp_dst   (cmp_dst),
      .pop_en    (pop_en),
      .flush     (recover),
      .head_tag  (head_tag),
      .head_done (head_done),
      .head_has  (head_has),
      .head_dst  (head_dst),
      .head_val  (head_val),
      .head_exc  (head_exc)
   );

   sr_future_file #(.NREG(NREG), .DW(DW), .TW(TW), .NSRC(NSRC), .FWD_EN(FWD_EN)) u_spec (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_idx       (ren_src_idx),
      .rd_rdy       (src_ready),
      .rd_val       (src_value),
      .rd_tag       (src_tag),
      .alloc_en     (alloc_en & ren_has_dst),
      .alloc_idx    (ren_dst_idx),
      .alloc_tag    (tail_tag),
      .res_en       (res_en),
      .res_idx      (cmp_dst),
      .res_tag      (cmp_tag),
      .res_val      (cmp_value),
      .restore      (recover),
      .restore_vals (arch_snap)
   );

   sr_commit_file #(.NREG(NREG), .DW(DW)) u_commit (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pop_en & head_has),
      .wr_idx  (head_dst),
      .wr_data (head_val),
      .snap    (arch_snap)
   );

   a_r9_recover_blocks_rename: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (ren_tag == '0 && !grad_valid));

   a_r3_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && !recover) |=> (ren_tag == $past(ren_tag) + TW'(1)));
endmodule

// File: tb/tb_spec_rename_core.sv
`timescale 1ns/1ps
module tb_spec_rename_core;
   localparam int NREG = 8, DW = 16, DEPTH = 8, NSRC = 2;
   localparam int AW = $clog2(NREG), TW = $clog2(DEPTH);

   logic clk = 1'b0, rst_n = 1'b0;
   logic ren_valid = 0, ren_has_dst = 0, cmp_valid = 0, cmp_flag = 0;
   logic [NSRC*AW-1:0] ren_src_idx = '0;
   logic [AW-1:0] ren_dst_idx = '0;
   logic [TW-1:0] cmp_tag = '0;
   logic [DW-1:0] cmp_value = '0;
   logic ren_stall, grad_valid, grad_wr, recover;
   logic [TW-1:0] ren_tag, grad_tag;
   logic [NSRC-1:0] src_ready;
   logic [NSRC*DW-1:0] src_value;
   logic [NSRC*TW-1:0] src_tag;
   logic [AW-1:0] grad_dst;
   logic [DW-1:0] grad_value;

   always #4 clk = ~clk;

   spec_rename_core #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH), .NSRC(NSRC)) dut (.*);

   int checks = 0, errors = 0;
   // reference model state
   bit m_rdy[NREG]; int m_val[NREG]; int m_tag[NREG]; int m_arch[NREG]; bit m_stale[NREG];
   bit b_busy[DEPTH], b_done[DEPTH], b_exc[DEPTH], b_has[DEPTH];
   int b_dst[DEPTH], b_val[DEPTH];
   int m_head, m_tail, m_count;
   bit in_reset, post_rec;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_init();
      for (int r = 0; r < NREG; r++) begin
         m_rdy[r] = 1; m_val[r] = 0; m_tag[r] = 0; m_arch[r] = 0; m_stale[r] = 0;
      end
      for (int t = 0; t < DEPTH; t++) begin
         b_busy[t] = 0; b_done[t] = 0; b_exc[t] = 0; b_has[t] = 0;
      end
      m_head = 0; m_tail = 0; m_count = 0;
   endtask

   task automatic step(input bit rv, input int s0, input int s1, input bit hd, input int d,
                       input bit cv, input int ct, input int cval, input bit cx);
      bit e_gv, e_rec, e_stall, e_res, acc;
      int srcs[NSRC];
      @(negedge clk);
      srcs[0] = s0; srcs[1] = s1;
      ren_valid = rv; ren_has_dst = hd; ren_dst_idx = AW'(d);
      ren_src_idx = {AW'(s1), AW'(s0)};
      cmp_valid = cv; cmp_tag = TW'(ct); cmp_value = DW'(cval); cmp_flag = cx;
      #1;
      e_gv = b_busy[m_head] && b_done[m_head];
      e_rec = e_gv && b_exc[m_head];
      e_stall = (m_count == DEPTH) || e_rec;
      e_res = cv && b_busy[ct] && !b_done[ct] && b_has[ct] && !e_rec;
      chk(in_reset ? "R1" : (e_rec ? "R9" : "R4"), "stall", int'(ren_stall), int'(e_stall));
      chk(in_reset ? "R1" : "R3", "next id", int'(ren_tag), m_tail);
      chk(e_rec ? "R9" : "R5", "recover", int'(recover), int'(e_rec));
      chk(in_reset ? "R1" : "R5", "retire valid", int'(grad_valid), int'(e_gv));
      if (e_gv) begin
         chk("R5", "retire id", int'(grad_tag), m_head);
         chk("R5", "retire wr", int'(grad_wr), int'(b_has[m_head]));
         if (b_has[m_head]) chk("R5", "retire dst", int'(grad_dst), b_dst[m_head]);
         chk("R5", "retire value", int'(grad_value), b_val[m_head]);
      end
      for (int s = 0; s < NSRC; s++) begin
         int r; bit fwd; string lab;
         r = srcs[s];
         fwd = e_res && b_dst[ct] == r && !m_rdy[r] && m_tag[r] == ct;
         lab = in_reset ? "R1" : post_rec ? "R8" : fwd ? "R7" : m_stale[r] ? "R6" : "R2";
         if (m_rdy[r] || fwd) begin
            chk(lab, "src ready", int'(src_ready[s]), 1);
            chk(lab, "src value", int'(src_value[s*DW +: DW]), fwd ? cval : m_val[r]);
         end else begin
            chk(lab, "src ready", int'(src_ready[s]), 0);
            chk(lab, "src id", int'(src_tag[s*TW +: TW]), m_tag[r]);
         end
      end
      // model update for the coming clock edge
      post_rec = 0;
      acc = rv && !e_stall;
      if (e_rec) begin
         for (int r = 0; r < NREG; r++) begin
            m_rdy[r] = 1; m_val[r] = m_arch[r]; m_stale[r] = 0;
         end
         for (int t = 0; t < DEPTH; t++) b_busy[t] = 0;
         m_head = 0; m_tail = 0; m_count = 0;
         post_rec = 1;
      end else begin
         if (e_gv) begin
            if (b_has[m_head]) m_arch[b_dst[m_head]] = b_val[m_head];
            b_busy[m_head] = 0; m_head = (m_head + 1) % DEPTH; m_count--;
         end
         if (cv && b_busy[ct] && !b_done[ct]) begin
            b_done[ct] = 1; b_val[ct] = cval & 16'hFFFF; b_exc[ct] = cx;
            if (b_has[ct]) begin
               if (!m_rdy[b_dst[ct]] && m_tag[b_dst[ct]] == ct) begin
                  m_rdy[b_dst[ct]] = 1; m_val[b_dst[ct]] = cval & 16'hFFFF; m_stale[b_dst[ct]] = 0;
               end else m_stale[b_dst[ct]] = 1;
            end
         end
         if (acc) begin
            b_busy[m_tail] = 1; b_done[m_tail] = 0; b_exc[m_tail] = 0;
            b_has[m_tail] = hd; b_dst[m_tail] = d;
            if (hd) begin m_rdy[d] = 0; m_tag[d] = m_tail; m_stale[d] = 0; end
            m_tail = (m_tail + 1) % DEPTH; m_count++;
         end
      end
   endtask

   function automatic int pick_open();
      int start;
      start = int'($urandom % DEPTH);
      for (int k = 0; k < DEPTH; k++) begin
         int t;
         t = (start + k) % DEPTH;
         if (b_busy[t] && !b_done[t]) return t;
      end
      return -1;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      model_init();
      in_reset = 1; post_rec = 0;
      repeat (3) @(posedge clk);
      rst_n = 1;
      // R1: reset state of all registers
      for (int r = 0; r < NREG; r += 2) step(0, r, r + 1, 0, 0, 0, 0, 0, 0);
      in_reset = 0;
      // R3 same-register source, R6 older writer, R7 forwarding
      step(1, 2, 2, 1, 2, 0, 0, 0, 0);
      step(1, 2, 3, 1, 2, 0, 0, 0, 0);
      step(1, 2, 1, 0, 0, 1, 0, 16'h1111, 0);
      step(1, 2, 2, 0, 0, 1, 1, 16'h2222, 0);
      // R4: fill the buffer until it stalls
      for (int i = 0; i < DEPTH + 2; i++) step(1, i % NREG, 5, 1, i % NREG, 0, 0, 0, 0);
      // drain in order, with a recovery request on a later operation (R8, R9)
      for (int i = 0; i < 3 * DEPTH; i++) begin
         int t;
         t = pick_open();
         step(0, i % NREG, 2, 0, 0, t >= 0, t < 0 ? 0 : t, int'($urandom & 16'hFFFF), t == 6);
      end
      // constrained random phases
      for (int i = 0; i < 4000; i++) begin
         bit busy_phase; int t; bit rv, cv;
         busy_phase = ((i / 150) % 2) == 0;
         rv = ($urandom % 100) < (busy_phase ? 90 : 40);
         t = pick_open();
         cv = (t >= 0) && (($urandom % 100) < (busy_phase ? 35 : 85));
         step(rv, int'($urandom % NREG), int'($urandom % NREG), ($urandom % 4) != 0,
              int'($urandom % NREG), cv, cv ? t : 0, int'($urandom & 16'hFFFF),
              ($urandom % 40) == 0);
      end
      @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule